// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block runs a single external bus transfer for a microcontroller-style bus master. It works with a shared address/data bus or with separate address and data lines. The choice is made for each transfer. In shared (multiplexed) mode, the first clock of the cycle places the address on the shared lines and raises an address-latch strobe so an outside device can hold on to it. The shared lines then carry the data. In separate mode the cycle starts straight in the data phase, and the address stays on its own lines for the whole cycle.

During the data phase a data strobe is raised. Distinct read and write strobes are derived from it and from the latched direction. Two sources can end the data phase. The first is an internal chip-select acknowledge, which fires after a programmed number of wait clocks. The second is an external acknowledge input, which counts only when it is enabled for the transfer. Whichever comes first ends the phase. On a read, the data on the input lines is captured on that acknowledge. One further clock reports completion, and then the block returns to idle.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset and while idle, busy_o, done_o, ale_o, ds_o, rd_o, wr_o and ad_oe_o are all 0.
- R2: In multiplexed mode (mux_i=1 at the request), the first busy clock has ale_o=1, ad_oe_o=1 and ds_o=0, with the latched address on ad_o (zero-extended or truncated to DATA_W bits). ale_o is high for exactly that one clock.
- R3: During a read data phase ad_oe_o=0. During a write data phase ad_oe_o=1 and ad_o carries the latched write data.
- R4: With no external acknowledge, the data phase (ds_o=1) lasts wait_i+1 clocks, where wait_i ranges from 0 to 15 and is latched at the request.
- R5: If ext_ack_en_i=1 was latched at the request and ext_ack_i=1 in data clock k (counting from 0) with k below the wait count, the data phase ends after clock k. If it was latched as 0, ext_ack_i has no effect.
- R6: On a read (rnw_i=1), rdata_o holds the value that ad_i had in the last data-phase clock, from the completion clock onward.
- R7: rd_o equals ds_o AND read, and wr_o equals ds_o AND write. The two are never high together.
- R8: busy_o is high from the clock after the accepted request through the completion clock. done_o is high for only that completion clock, which follows the acknowledge clock, and busy_o is 0 in the clock after it.
- R9: req_i is accepted only when idle. Request and configuration inputs that change while busy do not alter the running cycle and do not start a new one.
- R10: In separate mode (mux_i=0), ale_o stays 0, the data phase starts in the first busy clock, and addr_o carries the latched address in every busy clock.
- R11: ad_oe_o is 0 in the completion clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a transfer (sampled when idle) |
| rnw_i | input | 1 | 1 = read, 0 = write |
| mux_i | input | 1 | 1 = shared address/data bus |
| addr_i | input | ADDR_W | Transfer address |
| wdata_i | input | DATA_W | Write data |
| wait_i | input | WAIT_W | Chip-select wait clocks |
| ext_ack_en_i | input | 1 | Enable the external acknowledge input |
| ext_ack_i | input | 1 | External acknowledge, active high |
| ad_i | input | DATA_W | Data lines as seen at the pins |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | Completion clock |
| ale_o | output | 1 | Address-latch strobe |
| ds_o | output | 1 | Data strobe |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| ad_o | output | DATA_W | Value driven on the data/shared lines |
| ad_oe_o | output | 1 | Output enable for ad_o |
| addr_o | output | ADDR_W | Address lines in separate mode |
| rdata_o | output | DATA_W | Captured read data |

## Verification
The assertions assume that ext_ack_i is raised only while the data strobe is up. They also assume that the configuration seen at a request is the configuration wanted for the whole cycle. The stimulus pulses the external acknowledge only in a chosen data clock, and otherwise holds it low. While busy it drives random junk on req_i, addr_i, wdata_i, mux_i and rnw_i, and it drops req_i in the completion clock so that the idle check which follows is clean.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_DONE = 2'd3
  } bcs_state_e;
endpackage

// File: rtl/bcs_wait_ctr.sv
module bcs_wait_ctr #(
  parameter int WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [WAIT_W-1:0] limit_i,
  output logic              cs_ack_o
);
  logic [WAIT_W-1:0] cnt_q;

  assign cs_ack_o = run_i && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!run_i)   cnt_q <= '0;
    else if (!cs_ack_o) cnt_q <= cnt_q + 1'b1;
  end

  // R4: count never passes the programmed limit while running
  a_r4_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= limit_i);
  a_r4_cnt_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/bcs_strobe_gen.sv
module bcs_strobe_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rnw_i,
  input  logic ds_i,
  output logic rd_o,
  output logic wr_o
);
  assign rd_o = ds_i &  rnw_i;
  assign wr_o = ds_i & ~rnw_i;

  // R7
  a_r7_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));
  a_r7_need_ds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o || wr_o) |-> ds_i);
endmodule

// File: rtl/bcs_ad_drv.sv
module bcs_ad_drv
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bcs_state_e        state_i,
  input  logic              mux_i,
  input  logic              rnw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ale_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [DATA_W-1:0] addr_on_ad;

  generate
    if (ADDR_W >= DATA_W) begin : g_trunc
      assign addr_on_ad = addr_i[DATA_W-1:0];
    end else begin : g_zext
      assign addr_on_ad = {{(DATA_W-ADDR_W){1'b0}}, addr_i};
    end
  endgenerate

  always_comb begin
    ale_o   = 1'b0;
    ad_o    = '0;
    ad_oe_o = 1'b0;
    addr_o  = '0;
    unique case (state_i)
      ST_ADDR: begin
        ale_o   = 1'b1;
        ad_o    = addr_on_ad;
        ad_oe_o = 1'b1;
      end
      ST_DATA: begin
        ad_oe_o = ~rnw_i;
        if (!rnw_i) ad_o = wdata_i;
        if (!mux_i) addr_o = addr_i;
      end
      ST_DONE: begin
        if (!mux_i) addr_o = addr_i;
      end
      default: ;
    endcase
  end

  // R3: read data phase never drives the bus
  a_r3_read_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_DATA && rnw_i) |-> !ad_oe_o);
  // R11
  a_r11_oe_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_DONE) |-> !ad_oe_o);
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              rnw_i,
  input  logic              mux_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic              ext_ack_en_i,
  input  logic              ext_ack_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ale_o,
  output logic              ds_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] rdata_o
);
  bcs_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [WAIT_W-1:0] wait_q;
  logic              rnw_q, mux_q, ext_en_q;
  logic              cs_ack, ack, in_data;

  assign in_data = (state_q == ST_DATA);
  assign ack     = in_data && (cs_ack || (ext_en_q && ext_ack_i));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_i) state_d = mux_i ? ST_ADDR : ST_DATA;
      ST_ADDR: state_d = ST_DATA;
      ST_DATA: if (ack) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      wdata_q  <= '0;
      wait_q   <= '0;
      rnw_q    <= 1'b1;
      mux_q    <= 1'b0;
      ext_en_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_i) begin
        addr_q   <= addr_i;
        wdata_q  <= wdata_i;
        wait_q   <= wait_i;
        rnw_q    <= rnw_i;
        mux_q    <= mux_i;
        ext_en_q <= ext_ack_en_i;
      end
      if (ack && rnw_q) rdata_q <= ad_i;
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = (state_q == ST_DONE);
  assign ds_o    = in_data;
  assign rdata_o = rdata_q;

  bcs_wait_ctr #(.WAIT_W(WAIT_W)) u_wait (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (in_data),
    .limit_i  (wait_q),
    .cs_ack_o (cs_ack)
  );

  bcs_strobe_gen u_strb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rnw_i  (rnw_q),
    .ds_i   (ds_o),
    .rd_o   (rd_o),
    .wr_o   (wr_o)
  );

  bcs_ad_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_i (state_q),
    .mux_i   (mux_q),
    .rnw_i   (rnw_q),
    .addr_i  (addr_q),
    .wdata_i (wdata_q),
    .ale_o   (ale_o),
    .ad_o    (ad_o),
    .ad_oe_o (ad_oe_o),
    .addr_o  (addr_o)
  );

  // R2: address strobe lasts one clock and hands over to data
  a_r2_ale_one_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o && ds_o);
  // R5: enabled external acknowledge ends the data phase at once
  a_r5_ext_cut: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ds_o && ext_en_q && ext_ack_i) |=> done_o && !ds_o);
  // R8
  a_r8_done_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ds_o && !$stable(ds_o) == 1'b0 && cs_ack) |=> done_o && busy_o);
  a_r8_idle_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  // R9: a running cycle is not restarted
  a_r9_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  // R10
  a_r10_no_ale_sep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mux_q) |-> !ale_o);
endmodule

// File: tb/bus_cycle_seq_tb.sv
module bus_cycle_seq_tb;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int WW = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0, rnw_i = 1'b0, mux_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0, ad_i = '0;
  logic [WW-1:0] wait_i = '0;
  logic          ext_ack_en_i = 1'b0, ext_ack_i = 1'b0;
  logic          busy_o, done_o, ale_o, ds_o, rd_o, wr_o, ad_oe_o;
  logic [DW-1:0] ad_o, rdata_o;
  logic [AW-1:0] addr_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  bus_cycle_seq #(.ADDR_W(AW), .DATA_W(DW), .WAIT_W(WW)) u_dut (
    .clk_i, .rst_ni, .req_i, .rnw_i, .mux_i, .addr_i, .wdata_i, .wait_i,
    .ext_ack_en_i, .ext_ack_i, .ad_i, .busy_o, .done_o, .ale_o, .ds_o,
    .rd_o, .wr_o, .ad_o, .ad_oe_o, .addr_o, .rdata_o
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_data_len(input int w, input bit en, input int k);
    return (en && k < w) ? k + 1 : w + 1;
  endfunction

  task automatic do_cycle(input bit mux, input bit rnw, input int w, input bit en, input int k);
    logic [AW-1:0] a;
    logic [DW-1:0] wd, exp_rd;
    int len;
    a = AW'($urandom);
    wd = DW'($urandom);
    exp_rd = '0;
    len = exp_data_len(w, en, k);
    @(negedge clk_i);
    chk(busy_o == 1'b0, "R9 idle before request", 32'(busy_o), 0);
    req_i = 1'b1; mux_i = mux; rnw_i = rnw; addr_i = a; wdata_i = wd;
    wait_i = WW'(w); ext_ack_en_i = en;
    @(negedge clk_i);
    // junk while busy (R9)
    req_i = 1'($urandom); addr_i = AW'($urandom); wdata_i = DW'($urandom);
    mux_i = 1'($urandom); rnw_i = 1'($urandom); wait_i = WW'($urandom);
    ext_ack_en_i = 1'($urandom);
    chk(busy_o == 1'b1, "R8 busy at start", 32'(busy_o), 1);
    if (mux) begin
      chk(ale_o && ad_oe_o && !ds_o, "R2 address phase strobes",
          {29'd0, ale_o, ad_oe_o, ds_o}, 32'b110);
      chk(ad_o == DW'(a), "R2 address on shared bus", 32'(ad_o), 32'(a));
      @(negedge clk_i);
      req_i = 1'($urandom);
    end else begin
      chk(ale_o == 1'b0, "R10 no address strobe", 32'(ale_o), 0);
    end
    for (int d = 0; d < len; d++) begin
      chk(ds_o == 1'b1, "R4 data strobe length", 32'(ds_o), 1);
      chk(rd_o == rnw && wr_o == !rnw, "R7 strobe split",
          {30'd0, rd_o, wr_o}, {30'd0, rnw, !rnw});
      chk(ad_oe_o == !rnw, "R3 output enable in data phase", 32'(ad_oe_o), 32'(!rnw));
      if (!rnw) chk(ad_o == wd, "R3 write data on bus", 32'(ad_o), 32'(wd));
      if (!mux) chk(addr_o == a, "R10 address lines", 32'(addr_o), 32'(a));
      chk(done_o == 1'b0, "R8 no early done", 32'(done_o), 0);
      ext_ack_i = (d == k);
      ad_i = DW'($urandom);
      exp_rd = ad_i;
      req_i = 1'($urandom);
      @(negedge clk_i);
    end
    ext_ack_i = 1'b0;
    req_i = 1'b0;
    chk(done_o && busy_o && !ds_o, "R5 R8 completion after acknowledge",
        {29'd0, done_o, busy_o, ds_o}, 32'b110);
    chk(ad_oe_o == 1'b0, "R11 enable released", 32'(ad_oe_o), 0);
    chk(!rd_o && !wr_o, "R7 strobes off", {30'd0, rd_o, wr_o}, 0);
    if (rnw) chk(rdata_o == exp_rd, "R6 read capture", 32'(rdata_o), 32'(exp_rd));
    @(negedge clk_i);
    chk(!busy_o && !done_o, "R8 back to idle", {30'd0, busy_o, done_o}, 0);
    if (rnw) chk(rdata_o == exp_rd, "R6 read data held", 32'(rdata_o), 32'(exp_rd));
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1357));
    repeat (2) @(negedge clk_i);
    chk(!busy_o && !done_o && !ale_o && !ds_o && !rd_o && !wr_o && !ad_oe_o,
        "R1 reset state", {25'd0, busy_o, done_o, ale_o, ds_o, rd_o, wr_o, ad_oe_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !ad_oe_o, "R1 idle after reset", {30'd0, busy_o, ad_oe_o}, 0);
    // directed corners
    do_cycle(1'b1, 1'b1, 0, 1'b0, 99);   // R4 zero wait, mux read
    do_cycle(1'b0, 1'b0, 15, 1'b0, 99);  // R4 max wait, separate write
    do_cycle(1'b1, 1'b0, 7, 1'b1, 0);    // R5 external ack in first data clock
    do_cycle(1'b0, 1'b1, 9, 1'b1, 4);    // R5 external cuts short
    do_cycle(1'b1, 1'b1, 6, 1'b0, 2);    // R5 pin disabled: ignored
    do_cycle(1'b0, 1'b0, 3, 1'b1, 3);    // R5 tie with chip-select
    for (int i = 0; i < 200; i++)
      do_cycle(1'($urandom), 1'($urandom), int'($urandom_range(0, 15)),
               1'($urandom), int'($urandom_range(0, 17)));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule